// File: doc/BRIEF.md
# Host command pacing controller

This block sits between a host sequencer and an I2C master. It holds back each command and each result read until the target has had enough time to prepare the answer. A caller presents one request at a time with a two-bit class tag. The block answers with a pulse that starts the write phase. Once the I2C master reports that the write is finished, the block counts out the wait for that class. It then gives a second pulse that starts the result read. The same `xfer_done` input closes both the write phase and the read phase.

Every time in the block is given in milliseconds and turned into clock cycles at elaboration, using the clock-frequency parameter. Two constraints apply across commands rather than within one:

- Successive result reads must keep a minimum gap between them.
- Standard commands are limited to a fixed count per sliding one-second window. This keeps the target's watchdog from firing.

A `stall` flag reports whenever a request or a result read is being held back by one of these rules.

Top module: `pacing_ctrl`

## Requirements
- R1: After reset, `grant_cmd`, `grant_read` and `stall` are low while `req_valid` is low, and the block is ready for a request.
- R2: Class code 0 (control subcommand) has a wait of CTRL_MS. If the write finishes in cycle d, the first `grant_read` is in cycle d+1+CTRL_MS*CLK_HZ/1000, unless the read gap (R6) ends later.
- R3: Class code 1 (checksum subcommand) follows the same rule as R2, with a wait of CSUM_MS (100 ms by default).
- R4: Class code 2 (read-write standard command) follows the same rule as R2, with a wait of RW_MS (2 s by default).
- R5: Class code 3 (read-only standard command) has no class wait. `grant_read` is in cycle d+1, unless the read gap ends later.
- R6: If a read finishes in cycle r, the next `grant_read` comes no earlier than cycle r+1+GAP_MS*CLK_HZ/1000. When both this bound and the class wait apply, `grant_read` is in the later of the two cycles.
- R7: Standard commands are the classes with tag bit 1 set (codes 2 and 3). At most RATE_MAX of them receive `grant_cmd` in any window of WIN_MS*CLK_HZ/1000 cycles. A further standard request is granted exactly when the oldest grant in the window becomes that many cycles old.
- R8: Classes 0 and 1 are never held by the rate limit. They are granted in the first cycle the block is idle and the request is present.
- R9: Only one command is in flight. From `grant_cmd` until the read's `xfer_done`, no further `grant_cmd` is given, even if `req_valid` stays high. `grant_cmd` and `grant_read` each last one cycle.
- R10: `stall` is high in these cycles, and low in all others:
  - while a granted command waits for its read permission;
  - while a present standard request is refused by the rate limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A command request is present |
| req_class | input | 2 | Class tag: 0 control, 1 checksum, 2 read-write standard, 3 read-only standard |
| xfer_done | input | 1 | One-cycle pulse from the I2C master: the current phase has completed |
| grant_cmd | output | 1 | One-cycle pulse: start the command write |
| grant_read | output | 1 | One-cycle pulse: start the result read |
| stall | output | 1 | A request or a read is being held back |

## Verification
Two timers can release the result read in the same cycle: the per-class wait and the gap since the previous read. A read-only command with no class wait makes this easy to provoke. The bench sweeps the write-phase length so that the end of the write falls just before, exactly on, and just after the point where the read gap expires. It judges each case by comparing the `grant_read` cycle with the later of the two bounds, both worked out in the bench. The same sweep also runs into the rate limit, so stall cycles and the held-off grant are checked against the age of the oldest standard grant.

// File: rtl/pacing_ctrl.sv
module pacing_ctrl #(
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter int unsigned CTRL_MS  = 66,
  parameter int unsigned CSUM_MS  = 100,
  parameter int unsigned RW_MS    = 2000,
  parameter int unsigned GAP_MS   = 66,
  parameter int unsigned WIN_MS   = 1000,
  parameter int unsigned RATE_MAX = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_class,
  input  logic       xfer_done,
  output logic       grant_cmd,
  output logic       grant_read,
  output logic       stall
);

  localparam int unsigned CPM    = CLK_HZ / 1000;
  localparam int unsigned T_CTRL = CPM * CTRL_MS;
  localparam int unsigned T_CSUM = CPM * CSUM_MS;
  localparam int unsigned T_RW   = CPM * RW_MS;
  localparam int unsigned T_GAP  = CPM * GAP_MS;
  localparam int unsigned T_WIN  = CPM * WIN_MS;
  localparam int unsigned M1     = (T_CTRL > T_CSUM) ? T_CTRL : T_CSUM;
  localparam int unsigned M2     = (T_RW > T_GAP) ? T_RW : T_GAP;
  localparam int unsigned M3     = (M1 > M2) ? M1 : M2;
  localparam int unsigned MAXT   = (M3 > T_WIN) ? M3 : T_WIN;
  localparam int unsigned CW     = $clog2(MAXT + 1);

  typedef enum logic [1:0] {S_IDLE, S_WRITE, S_WAIT, S_READ} st_t;

  st_t               st;
  logic [1:0]        cls_q;
  logic [CW-1:0]     wait_q, gap_q;
  logic [RATE_MAX-1:0] busy, pick;
  logic              std_req, rate_full, read_ok;

  function automatic logic [CW-1:0] wait_for(input logic [1:0] c);
    case (c)
      2'd0:    return CW'(T_CTRL);
      2'd1:    return CW'(T_CSUM);
      2'd2:    return CW'(T_RW);
      default: return '0;
    endcase
  endfunction

  assign std_req    = req_class[1];
  assign rate_full  = &busy;
  assign read_ok    = (wait_q == '0) && (gap_q == '0);
  assign grant_cmd  = (st == S_IDLE) && req_valid && !(std_req && rate_full);
  assign grant_read = (st == S_WAIT) && read_ok;
  assign stall      = ((st == S_IDLE) && req_valid && std_req && rate_full) ||
                      ((st == S_WAIT) && !read_ok);

  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < RATE_MAX; i++) begin
      if (!busy[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < RATE_MAX; i++) begin : g_slot
    logic [CW-1:0] age_q;
    assign busy[i] = (age_q != '0);
    always_ff @(posedge clk) begin
      if (!rst_n)                              age_q <= '0;
      else if (grant_cmd && std_req && pick[i]) age_q <= CW'(T_WIN - 1);
      else if (busy[i])                        age_q <= age_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cls_q  <= '0;
      wait_q <= '0;
    end else begin
      case (st)
        S_IDLE:  if (grant_cmd) begin
                   st    <= S_WRITE;
                   cls_q <= req_class;
                 end
        S_WRITE: if (xfer_done) begin
                   st     <= S_WAIT;
                   wait_q <= wait_for(cls_q);
                 end
        S_WAIT:  if (read_ok) st <= S_READ;
                 else if (wait_q != '0) wait_q <= wait_q - 1'b1;
        default: if (xfer_done) st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          gap_q <= '0;
    else if (st == S_READ && xfer_done)  gap_q <= CW'(T_GAP);
    else if (gap_q != '0)                gap_q <= gap_q - 1'b1;
  end

  logic [31:0] since_rd;
  always_ff @(posedge clk) begin
    if (!rst_n)                          since_rd <= 32'hFFFF_FFFF;
    else if (st == S_READ && xfer_done)  since_rd <= '0;
    else if (since_rd != 32'hFFFF_FFFF)  since_rd <= since_rd + 1;
  end

  a_r6_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
    grant_read |-> (since_rd >= T_GAP));

  a_r2_wait_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WRITE && xfer_done && cls_q != 2'd3) |=> !grant_read);

  a_r9_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    grant_cmd |=> !grant_cmd && !grant_read);

  a_r10_stall_when_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && req_valid && !grant_cmd) |-> stall);

endmodule

// File: tb/pacing_ctrl_tb.sv
module pacing_ctrl_tb;
  localparam int W   = 1000;
  localparam int GAP = 66;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_class = 2'd0;
  logic xfer_done = 1'b0;
  logic grant_cmd, grant_read, stall;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int g_old = -100000;
  int g_new = -100000;
  int r_last = -100000;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pacing_ctrl #(.CLK_HZ(1000)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
    .xfer_done(xfer_done), .grant_cmd(grant_cmd), .grant_read(grant_read),
    .stall(stall)
  );

  always @(posedge clk) begin
    if (cyc == 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int cls_wait(input int c);
    case (c)
      0: return 66;
      1: return 100;
      2: return 2000;
      default: return 0;
    endcase
  endfunction

  task automatic run(input int cls, input int wdl, input int rdl);
    int gexp, g, d, rexp, rcls, rgap, rd, guard;
    bit bad_busy, bad_stall;
    bad_busy = 0; bad_stall = 0;
    req_class = cls[1:0];
    req_valid = 1'b1;
    gexp = cyc;
    if (cls >= 2 && g_old + W > gexp) gexp = g_old + W;
    #1;
    guard = 0;
    while (!grant_cmd && guard < 5000) begin
      if (stall !== 1'b1) bad_stall = 1;
      @(negedge clk); #1; guard++;
    end
    g = cyc;
    if (cls >= 2) begin
      chk(g == gexp, "R7 std grant cycle", g, gexp);
      g_old = g_new; g_new = g;
    end else begin
      chk(g == gexp, "R8 non-std not rate limited", g, gexp);
    end
    if (stall !== 1'b0) bad_stall = 1;
    repeat (wdl) begin
      @(negedge clk); #1;
      if (grant_cmd || grant_read) bad_busy = 1;
      if (stall !== 1'b0) bad_stall = 1;
    end
    xfer_done = 1'b1;
    d = cyc;
    @(negedge clk); #1;
    xfer_done = 1'b0;
    rcls = d + 1 + cls_wait(cls);
    rgap = r_last + 1 + GAP;
    rexp = (rcls >= rgap) ? rcls : rgap;
    guard = 0;
    while (!grant_read && guard < 5000) begin
      if (stall !== 1'b1) bad_stall = 1;
      if (grant_cmd) bad_busy = 1;
      @(negedge clk); #1; guard++;
    end
    rd = cyc;
    if (rgap > rcls)
      chk(rd == rexp, "R6 read gap bound", rd, rexp);
    else case (cls)
      0: chk(rd == rexp, "R2 control wait", rd, rexp);
      1: chk(rd == rexp, "R3 checksum wait", rd, rexp);
      2: chk(rd == rexp, "R4 rw standard wait", rd, rexp);
      default: chk(rd == rexp, "R5 ro standard no wait", rd, rexp);
    endcase
    if (stall !== 1'b0) bad_stall = 1;
    repeat (rdl) begin
      @(negedge clk); #1;
      if (grant_cmd || grant_read) bad_busy = 1;
      if (stall !== 1'b0) bad_stall = 1;
    end
    xfer_done = 1'b1;
    req_valid = 1'b0;
    r_last = cyc;
    @(negedge clk); #1;
    xfer_done = 1'b0;
    chk(!bad_busy, "R9 one command in flight", bad_busy, 0);
    chk(!bad_stall, "R10 stall pattern", bad_stall, 0);
  endtask

  initial begin
    int wd [6] = '{1, 2, 33, 65, 66, 67};
    int cl [3] = '{0, 1, 3};
    repeat (3) @(negedge clk);
    #1;
    chk(grant_cmd == 0 && grant_read == 0 && stall == 0, "R1 outputs in reset", {grant_cmd, grant_read, stall}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(grant_cmd == 0 && grant_read == 0 && stall == 0, "R1 idle after reset", {grant_cmd, grant_read, stall}, 0);
    @(negedge clk);
    for (int c = 0; c < 3; c++)
      for (int k = 0; k < 6; k++)
        run(cl[c], wd[k], 3);
    run(3, 1, 1);
    run(3, 1, 1);
    run(0, 2, 1);
    run(1, 2, 1);
    run(3, 65, 1);
    run(2, 5, 2);
    run(2, 1, 1);
    run(3, 1, 1);
    @(negedge clk); #1;
    chk(grant_cmd == 0 && grant_read == 0 && stall == 0, "R10 quiet when idle", {grant_cmd, grant_read, stall}, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule